// File: doc/BRIEF.md
# SPI Memory Access Channel

This block is an SPI slave that lets a host controller read and write external memory directly. It is driven by framed SPI transactions. Chip select going low opens a transaction. The first byte on the data-in line is a command code, and the bytes after it are a payload whose meaning depends on that code. Chip select going high closes the transaction, so a payload can be any length.

There are three commands. The first loads a persistent memory pointer. The second streams byte pairs into memory as 16-bit words. The third streams 16-bit words out of memory as byte pairs. After each word the pointer moves on by two, and it keeps its value from one transaction to the next. A long transfer can therefore be split over several transactions.

On the memory side the block has a plain request/acknowledge port that carries one word per request. For reads, the block fetches one word ahead of the host, so each word is already held inside the block before its first bit goes out on the data-out line. SPI runs in mode 0 and is oversampled by the system clock. The memory's acknowledge latency plus about four system clocks must fit inside half an SCLK period.

Top module: `spi_mem_channel`

## Requirements
- R1: SPI runs in mode 0. Data-in is sampled on the rising SCLK edge, most significant bit first. Data-out changes only after falling SCLK edges and reads 0 during the command byte. The first byte of every transaction is the command code.
- R2: Command 0x01 loads the pointer from the next four bytes, most significant byte first. The new value takes effect after the fourth byte. Further bytes in the same transaction are ignored. If the transaction carries fewer than four bytes, the pointer is unchanged.
- R3: Command 0x02 forms a 16-bit word from each pair of payload bytes, with the first byte in bits [15:8]. Each word gives one write request at the pointer, and the pointer advances by 2 when that request is acknowledged.
- R4: If a write transaction ends on an odd payload byte, that byte is dropped. It causes no memory request and does not move the pointer.
- R5: Command 0x03 returns the memory words from the pointer upward on data-out, high byte first. The pointer advances by 2 for each word whose low byte has been handed to the shifter.
- R6: The pointer persists across transactions. A write or read with no new set-address continues where the previous one stopped.
- R7: Any other command code ignores the rest of its transaction. It causes no memory request and leaves the pointer unchanged.
- R8: A memory request stays asserted until it is acknowledged. While it is pending, its address, direction and write data stay constant.
- R9: After reset, no request is pending, data-out is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also oversamples SPI |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low; frames a command |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Word read, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |

## Verification
A wrong pointer shows up on mem_addr at the very next request. It also shows up as read data taken from the wrong word within the next two bytes shifted out. If the byte-pairing phase slips, the next write word has its halves swapped or shifted, and a read returns the wrong half first. A command decoder that leaks state between transactions makes a following unknown or partial command either raise a request or move the pointer, and the next write then lands at an unexpected address.

// File: rtl/smc_pkg.sv
package smc_pkg;

   typedef enum logic [2:0] {
      PH_CMD   = 3'd0,
      PH_ADDR  = 3'd1,
      PH_WRITE = 3'd2,
      PH_READ  = 3'd3,
      PH_SKIP  = 3'd4
   } smc_phase_e;

   localparam int WORD_W     = 16;
   localparam int WORD_BYTES = WORD_W / 8;

endpackage

// File: rtl/smc_spi_port.sv
module smc_spi_port #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       mosi,
   output logic       miso,
   output logic       sel,
   output logic [7:0] rx_byte,
   output logic       rx_valid,
   output logic       tx_load,
   input  logic [7:0] tx_byte
);

   initial begin
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $fatal(1, "SYNC_STAGES out of range");
   end

   logic [2:0] raw;
   logic [2:0] syn;
   assign raw = {sclk, cs_n, mosi};

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign syn = raw;
      end else begin : g_sync
         logic [2:0] chain [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= 3'b010;
            end else begin
               chain[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign syn = chain[SYNC_STAGES-1];
      end
   endgenerate

   logic       sclk_q;
   logic       rise, fall;
   logic [2:0] bit_cnt;
   logic [6:0] rx_sh;
   logic [7:0] tx_sh;

   assign sel     = ~syn[1];
   assign rise    = sel & syn[2] & ~sclk_q;
   assign fall    = sel & ~syn[2] & sclk_q;
   assign tx_load = fall & (bit_cnt == 3'd0);
   assign miso    = tx_sh[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         bit_cnt  <= '0;
         rx_sh    <= '0;
         rx_byte  <= '0;
         rx_valid <= 1'b0;
         tx_sh    <= '0;
      end else begin
         sclk_q   <= syn[2];
         rx_valid <= 1'b0;
         if (!sel) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
         end else begin
            if (rise) begin
               rx_sh   <= {rx_sh[5:0], syn[0]};
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) begin
                  rx_byte  <= {rx_sh, syn[0]};
                  rx_valid <= 1'b1;
               end
            end
            if (fall) begin
               if (bit_cnt == 3'd0) tx_sh <= tx_byte;
               else                 tx_sh <= {tx_sh[6:0], 1'b0};
            end
         end
      end
   end

   // R1: framing restarts whenever chip select is released
   assert_bitcnt_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (bit_cnt == 3'd0));

   // R1: data-out never moves without a falling SCLK edge
   assert_miso_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && $past(sel) && !fall) |=> $stable(miso));

endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
   import smc_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter logic [7:0]  CMD_SETA = 8'h01,
   parameter logic [7:0]  CMD_WR   = 8'h02,
   parameter logic [7:0]  CMD_RD   = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [7:0]        rx_byte,
   input  logic              rx_valid,
   input  logic              tx_load,
   output logic [7:0]        tx_byte,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_ack
);

   localparam int ADDR_BYTES         = ADDR_W / 8;
   localparam int CNT_W              = $clog2(ADDR_BYTES + 1);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   initial begin
      assert (ADDR_W % 8 == 0 && ADDR_W >= 16 && ADDR_W <= 64)
         else $fatal(1, "ADDR_W must be a byte multiple between 16 and 64");
      assert (CMD_SETA != CMD_WR && CMD_SETA != CMD_RD && CMD_WR != CMD_RD)
         else $fatal(1, "command codes must differ");
   end

   smc_phase_e        phase;
   logic [CNT_W-1:0]  addr_cnt;
   logic [ADDR_W-1:0] addr_sh;
   logic [ADDR_W-1:0] ptr;
   logic [7:0]        wr_hi;
   logic              wr_half;
   logic [WORD_W-1:0] rd_word;
   logic              rd_valid;
   logic              rd_half;

   always_comb begin
      tx_byte = 8'h00;
      if (phase == PH_READ && rd_valid)
         tx_byte = rd_half ? rd_word[7:0] : rd_word[15:8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_CMD;
         addr_cnt  <= '0;
         addr_sh   <= '0;
         ptr       <= '0;
         wr_hi     <= '0;
         wr_half   <= 1'b0;
         rd_word   <= '0;
         rd_valid  <= 1'b0;
         rd_half   <= 1'b0;
         mem_req   <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         if (mem_req && mem_ack) begin
            mem_req <= 1'b0;
            if (mem_we) ptr <= ptr + STEP;
            else begin
               rd_word  <= mem_rdata;
               rd_valid <= 1'b1;
            end
         end
         if (!sel) begin
            phase    <= PH_CMD;
            addr_cnt <= '0;
            wr_half  <= 1'b0;
            rd_half  <= 1'b0;
         end else if (rx_valid) begin
            case (phase)
               PH_CMD: begin
                  if (rx_byte == CMD_SETA)      phase <= PH_ADDR;
                  else if (rx_byte == CMD_WR)   phase <= PH_WRITE;
                  else if (rx_byte == CMD_RD) begin
                     phase    <= PH_READ;
                     rd_valid <= 1'b0;
                     rd_half  <= 1'b0;
                     mem_req  <= 1'b1;
                     mem_we   <= 1'b0;
                     mem_addr <= ptr;
                  end else                      phase <= PH_SKIP;
               end
               PH_ADDR: begin
                  if (addr_cnt < CNT_W'(ADDR_BYTES)) begin
                     addr_sh  <= {addr_sh[ADDR_W-9:0], rx_byte};
                     addr_cnt <= addr_cnt + 1'b1;
                     if (addr_cnt == CNT_W'(ADDR_BYTES - 1))
                        ptr <= {addr_sh[ADDR_W-9:0], rx_byte};
                  end
               end
               PH_WRITE: begin
                  if (!wr_half) begin
                     wr_hi   <= rx_byte;
                     wr_half <= 1'b1;
                  end else begin
                     wr_half   <= 1'b0;
                     mem_req   <= 1'b1;
                     mem_we    <= 1'b1;
                     mem_addr  <= ptr;
                     mem_wdata <= {wr_hi, rx_byte};
                  end
               end
               default: ;
            endcase
         end else if (tx_load && phase == PH_READ) begin
            if (!rd_half) begin
               rd_half <= 1'b1;
            end else begin
               rd_half  <= 1'b0;
               rd_valid <= 1'b0;
               ptr      <= ptr + STEP;
               mem_req  <= 1'b1;
               mem_we   <= 1'b0;
               mem_addr <= ptr + STEP;
            end
         end
      end
   end

   assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req);

   assert_req_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   assert_wr_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_we) |=> (ptr == $past(ptr) + STEP));

   assert_skip_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP && !(mem_req && mem_ack)) |=> ($stable(ptr) && !$rose(mem_req)));

endmodule

// File: rtl/spi_mem_channel.sv
module spi_mem_channel #(
   parameter int         ADDR_W      = 32,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] CMD_SETA    = 8'h01,
   parameter logic [7:0] CMD_WR      = 8'h02,
   parameter logic [7:0] CMD_RD      = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata,
   input  logic              mem_ack
);

   logic       sel;
   logic [7:0] rx_byte;
   logic       rx_valid;
   logic       tx_load;
   logic [7:0] tx_byte;

   smc_spi_port #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (spi_sclk),
      .cs_n     (spi_cs_n),
      .mosi     (spi_mosi),
      .miso     (spi_miso),
      .sel      (sel),
      .rx_byte  (rx_byte),
      .rx_valid (rx_valid),
      .tx_load  (tx_load),
      .tx_byte  (tx_byte)
   );

   smc_ctrl #(
      .ADDR_W   (ADDR_W),
      .CMD_SETA (CMD_SETA),
      .CMD_WR   (CMD_WR),
      .CMD_RD   (CMD_RD)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .rx_byte   (rx_byte),
      .rx_valid  (rx_valid),
      .tx_load   (tx_load),
      .tx_byte   (tx_byte),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack)
   );

   // R9: nothing is requested straight out of reset
   assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !mem_req);

endmodule

// File: tb/spi_mem_channel_tb.sv
`timescale 1ns/1ps
module spi_mem_channel_tb;

   localparam time        HALF = 60ns;
   localparam logic [7:0] C_SET = 8'h01, C_WR = 8'h02, C_RD = 8'h03;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata;

   always #2.5ns clk = ~clk;

   spi_mem_channel u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .spi_miso(miso), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack)
   );

   int vectors = 0, fails = 0;
   bit done = 1'b0;

   function automatic logic [15:0] init_word(int i);
      return 16'((i * 16'h0913) ^ 16'h5AC3);
   endfunction

   // memory model
   logic [15:0] model [64];
   int          lat, ack_delay = 1, req_count = 0, wcount = 0, r8_bad = 0;
   logic [31:0] wlog_addr [256];
   logic [15:0] wlog_data [256];
   logic [31:0] hold_addr;
   logic [15:0] hold_data;
   logic        hold_we;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) model[i] <= init_word(i);
         lat <= 0; mem_ack <= 1'b0; mem_rdata <= '0;
      end else begin
         mem_ack <= 1'b0;
         if (mem_req && !mem_ack) begin
            if (lat == 0) begin
               hold_addr <= mem_addr; hold_data <= mem_wdata; hold_we <= mem_we;
            end else if (mem_addr !== hold_addr || mem_we !== hold_we ||
                         (mem_we && mem_wdata !== hold_data)) begin
               r8_bad <= r8_bad + 1;
            end
            if (lat >= ack_delay) begin
               mem_ack   <= 1'b1;
               lat       <= 0;
               req_count <= req_count + 1;
               if (mem_we) begin
                  model[mem_addr[6:1]] <= mem_wdata;
                  if (wcount < 256) begin
                     wlog_addr[wcount] <= mem_addr;
                     wlog_data[wcount] <= mem_wdata;
                  end
                  wcount <= wcount + 1;
               end else begin
                  mem_rdata <= model[mem_addr[6:1]];
               end
            end else begin
               lat <= lat + 1;
            end
         end
      end
   end

   logic [15:0] exp_mem [64];
   logic [31:0] exp_ptr = '0;
   logic [31:0] a_reg;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %h expected %h", rq, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] t, output logic [7:0] r);
      for (int b = 7; b >= 0; b--) begin
         mosi = t[b];
         #(HALF);
         r[b] = miso;
         sclk = 1'b1;
         #(HALF);
         sclk = 1'b0;
      end
   endtask

   task automatic cs_open();
      cs_n = 1'b0;
      #(HALF);
   endtask

   task automatic cs_close();
      #(HALF);
      cs_n = 1'b1;
      #(4 * HALF);
   endtask

   task automatic set_addr(input logic [31:0] a, input int nbytes);
      logic [7:0] r;
      cs_open();
      xfer(C_SET, r);
      for (int i = 0; i < nbytes; i++)
         xfer((i < 4) ? a[31 - 8*i -: 8] : 8'hEE, r);
      cs_close();
      if (nbytes >= 4) exp_ptr = a;
   endtask

   function automatic logic [15:0] dat(int seed, int j);
      return 16'((seed * 16'h1111) ^ (j * 16'h0203) ^ 16'h8C01);
   endfunction

   task automatic write_seq(input int n, input int seed, input string rq, input bit odd);
      logic [7:0] r;
      int start;
      start = wcount;
      cs_open();
      xfer(C_WR, r);
      for (int j = 0; j < n; j++) begin
         xfer(dat(seed, j)[15:8], r);
         xfer(dat(seed, j)[7:0], r);
      end
      if (odd) xfer(8'hA7, r);
      cs_close();
      chk(wcount == start + n, rq, 32'(wcount - start), 32'(n));
      for (int j = 0; j < n; j++) begin
         chk(wlog_addr[start + j] == exp_ptr, rq, wlog_addr[start + j], exp_ptr);
         chk(wlog_data[start + j] == dat(seed, j), rq, 32'(wlog_data[start + j]),
             32'(dat(seed, j)));
         exp_mem[exp_ptr[6:1]] = dat(seed, j);
         exp_ptr = exp_ptr + 32'd2;
      end
   endtask

   task automatic read_seq(input int n);
      logic [7:0] r, hi, lo;
      cs_open();
      xfer(C_RD, r);
      chk(r == 8'h00, "R1", 32'(r), 32'h0);
      for (int j = 0; j < n; j++) begin
         xfer(8'h00, hi);
         xfer(8'h00, lo);
         chk({hi, lo} == exp_mem[exp_ptr[6:1]], "R5", 32'({hi, lo}),
             32'(exp_mem[exp_ptr[6:1]]));
         exp_ptr = exp_ptr + 32'd2;
      end
      cs_close();
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      report();
   end

   initial begin
      for (int i = 0; i < 64; i++) exp_mem[i] = init_word(i);
      #(33ns);
      rst_n = 1'b1;
      #(21ns);
      // R9: reset state
      chk(mem_req == 1'b0, "R9", 32'(mem_req), 32'h0);
      chk(miso == 1'b0, "R9", 32'(miso), 32'h0);
      write_seq(1, 9, "R9", 1'b0);   // pointer starts at 0

      // sweep: R2 addressing, R3 writes, R5 reads, varying latency (R8)
      for (int k = 0; k < 6; k++) begin
         a_reg = {8'(k) ^ 8'hC3, 8'h81, 8'(8'h40 + k), 8'(k * 6)};
         ack_delay = k % 4;
         set_addr(a_reg, 4);
         write_seq(k + 1, k, "R3", 1'b0);
         set_addr(a_reg, 4);
         read_seq(k + 1);
      end

      // R6: continuation across transactions
      ack_delay = 2;
      set_addr(32'h0000_1010, 4);
      write_seq(2, 11, "R6", 1'b0);
      write_seq(1, 12, "R6", 1'b0);
      set_addr(32'h0000_1010, 4);
      read_seq(1);
      read_seq(2);

      // R4: trailing odd byte dropped
      write_seq(2, 13, "R4", 1'b1);
      write_seq(1, 14, "R4", 1'b0);

      // R7: unknown codes
      for (int c = 0; c < 4; c++) begin
         logic [7:0] r;
         int rc;
         rc = req_count;
         cs_open();
         xfer((c == 0) ? 8'h00 : (c == 1) ? 8'h04 : (c == 2) ? 8'h7F : 8'hFF, r);
         xfer(C_WR, r); xfer(8'h12, r); xfer(8'h34, r); xfer(C_SET, r); xfer(8'h56, r);
         cs_close();
         chk(req_count == rc, "R7", 32'(req_count - rc), 32'h0);
      end
      write_seq(1, 15, "R7", 1'b0);

      // R2: extra bytes ignored, short load ignored
      set_addr(32'h8000_0024, 6);
      write_seq(1, 16, "R2", 1'b0);
      set_addr(32'h1111_1100, 3);
      write_seq(1, 17, "R2", 1'b0);
      set_addr(32'h8000_0024, 4);
      read_seq(2);

      // R8: request stability throughout
      chk(r8_bad == 0, "R8", 32'(r8_bad), 32'h0);
      report();
   end

endmodule